// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It divides its input clock by a 17-bit programmed ratio and emits one short pulse per output cycle, which the loop's phase comparator uses as the divided feedback. Internally the ratio is realised as a main count M and a swallow count A around a dual-modulus prescaler. The prescaler divides by 17 while the swallow counter is still running and by 16 after it has run out. Every output cycle therefore lasts 16·M + A prescaler input ticks. The prescaler is modelled as plain digital counters, and all logic runs on the input clock.

An optional divide-by-2 front stage sits ahead of the prescaler and doubles the overall ratio when it is selected. A test output toggles once per output cycle, giving a square wave at half the divided rate. An error flag warns when the programmed split cannot be produced, that is when the main count is zero or smaller than the swallow count.

A new ratio and front-stage choice are captured together on a one-cycle load strobe. They are held as pending and take effect only at the next output-cycle boundary, so a running cycle is never cut short. All pins are plain control and status signals with no handshake.

Top module: `pswd_divider`

## Requirements
- R1: While reset is low, and after reset until the first load has been adopted, fb_pulse, test_half and ratio_err are 0, and no pulse appears unless a load strobe arrives.
- R2: With the front stage bypassed (front_en = 0 at load), the distance between consecutive fb_pulse assertions is exactly 16·M + A input clock cycles. Here M = ratio_in[16:4] and A = ratio_in[3:0], and the ratio must satisfy M ≥ 1 and M ≥ A.
- R3: fb_pulse is high for exactly one input clock cycle per output cycle.
- R4: With front_en = 1 captured at load, the pulse spacing is 2·(16·M + A) input clock cycles.
- R5: A load strobe sampled at a rising edge stores ratio_in and front_en as pending. If the divider is idle, the pending values are adopted at the next edge and the first pulse is high in the cycle after P+1 edges from the strobe edge, where P is the spacing from R2 or R4. If the divider is running, the pending values are adopted at the edge that raises fb_pulse. A later strobe before that edge replaces an earlier one.
- R6: test_half changes value at the edge that ends each fb_pulse high cycle, and it holds at every other edge.
- R7: At the edge that samples load_stb, ratio_err becomes 1 if M = 0 or M < A, and 0 otherwise. It holds its value until the next load.
- R8: Within each output cycle the prescaler counts modulo 17 for the first A prescaler periods and modulo 16 for the remaining M − A periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_in | input | 17 | Ratio; [16:4] main count M, [3:0] swallow count A |
| front_en | input | 1 | 1 selects the divide-by-2 front stage, 0 bypasses it |
| load_stb | input | 1 | One-cycle strobe capturing ratio_in and front_en |
| fb_pulse | output | 1 | Divided feedback pulse, one cycle wide |
| test_half | output | 1 | Toggles once per output cycle (half-rate test output) |
| ratio_err | output | 1 | Last loaded ratio has M = 0 or M < A |

## Verification
ratio_err is due one edge after the strobe edge. The first pulse after an idle load is due P+1 edges after the strobe edge. Each later pulse follows the previous one by exactly P edges, and test_half moves one edge after each pulse. A behavioural model in the bench advances on the same edges as the design, using integer cycle counts and the pending/active ratio semantics. Its predicted values for all three outputs are compared at every falling edge, half a period away from the sampling edge, so every due cycle is checked exactly and a pulse one cycle early or late is a mismatch.

// File: rtl/pswd_pkg.sv
package pswd_pkg;
  localparam int DEF_A_W = 4;
  localparam int DEF_M_W = 13;

  function automatic logic split_bad(input int unsigned m, input int unsigned a);
    return (m == 0) || (m < a);
  endfunction
endpackage

// File: rtl/pswd_front.sv
module pswd_front (
  input  logic clk_in,
  input  logic rst_n,
  input  logic run,
  input  logic halve,
  input  logic restart,
  output logic tick
);
  logic tgl_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)       tgl_q <= 1'b0;
    else if (restart) tgl_q <= 1'b0;
    else if (run)     tgl_q <= ~tgl_q;
  end

  assign tick = run && (!halve || tgl_q);
endmodule

// File: rtl/pswd_prescaler.sv
module pswd_prescaler #(
  parameter int A_W = 4
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic mod_hi,
  output logic pre_term
);
  localparam int BASE_MOD = 1 << A_W;
  localparam int PRE_W    = A_W + 1;
  localparam logic [PRE_W-1:0] LAST_LO = PRE_W'(BASE_MOD - 1);
  localparam logic [PRE_W-1:0] LAST_HI = PRE_W'(BASE_MOD);

  logic [PRE_W-1:0] cnt_q;

  assign pre_term = tick && (cnt_q == (mod_hi ? LAST_HI : LAST_LO));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (pre_term) cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + PRE_W'(1);
  end

  AST_PRE_RANGE: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt_q <= LAST_HI); // R8
  AST_PRE_EXTRA_ONLY_SWALLOW: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cnt_q == LAST_HI) |-> mod_hi); // R8
endmodule

// File: rtl/pswd_counters.sv
module pswd_counters #(
  parameter int A_W = 4,
  parameter int M_W = 13
) (
  input  logic           clk_in,
  input  logic           rst_n,
  input  logic           restart,
  input  logic [M_W-1:0] ld_m,
  input  logic [A_W-1:0] ld_a,
  input  logic           pre_term,
  output logic           mod_hi,
  output logic           cycle_end
);
  logic [M_W-1:0] main_q;
  logic [A_W-1:0] swal_q;

  assign mod_hi    = (swal_q != '0);
  assign cycle_end = pre_term && (main_q == M_W'(1));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      swal_q <= '0;
    end else if (restart) begin
      main_q <= ld_m;
      swal_q <= ld_a;
    end else if (pre_term) begin
      main_q <= main_q - M_W'(1);
      if (mod_hi) swal_q <= swal_q - A_W'(1);
    end
  end
endmodule

// File: rtl/pswd_divider.sv
module pswd_divider
  import pswd_pkg::*;
#(
  parameter int A_W = DEF_A_W,
  parameter int M_W = DEF_M_W
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic [A_W+M_W-1:0] ratio_in,
  input  logic               front_en,
  input  logic               load_stb,
  output logic               fb_pulse,
  output logic               test_half,
  output logic               ratio_err
);
  localparam int R_W = A_W + M_W;

  logic [R_W-1:0] pend_r, act_r;
  logic           pend_fe, act_fe, pend_v, run_q;
  logic           pulse_q, half_q, err_q;
  logic           tick, pre_term, mod_hi, cycle_end, adopt, restart;
  logic [M_W-1:0] ld_m;
  logic [A_W-1:0] ld_a;

  assign adopt   = pend_v && (!run_q || cycle_end);
  assign restart = adopt || cycle_end;

  always_comb begin
    if (adopt) begin
      ld_m = pend_r[R_W-1:A_W];
      ld_a = pend_r[A_W-1:0];
    end else begin
      ld_m = act_r[R_W-1:A_W];
      ld_a = act_r[A_W-1:0];
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      pend_r  <= '0;
      pend_fe <= 1'b0;
      pend_v  <= 1'b0;
      act_r   <= '0;
      act_fe  <= 1'b0;
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
      half_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (load_stb) begin
        pend_r  <= ratio_in;
        pend_fe <= front_en;
        err_q   <= split_bad(int'(ratio_in[R_W-1:A_W]), int'(ratio_in[A_W-1:0]));
      end
      pend_v <= load_stb || (pend_v && !adopt);
      if (adopt) begin
        act_r  <= pend_r;
        act_fe <= pend_fe;
        run_q  <= 1'b1;
      end
      pulse_q <= cycle_end;
      half_q  <= half_q ^ pulse_q;
    end
  end

  pswd_front u_front (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .run    (run_q),
    .halve  (act_fe),
    .restart(restart),
    .tick   (tick)
  );

  pswd_prescaler #(.A_W(A_W)) u_pre (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (restart),
    .mod_hi  (mod_hi),
    .pre_term(pre_term)
  );

  pswd_counters #(.A_W(A_W), .M_W(M_W)) u_cnt (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .restart  (restart),
    .ld_m     (ld_m),
    .ld_a     (ld_a),
    .pre_term (pre_term),
    .mod_hi   (mod_hi),
    .cycle_end(cycle_end)
  );

  assign fb_pulse  = pulse_q;
  assign test_half = half_q;
  assign ratio_err = err_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_in) disable iff (!rst_n)
    !run_q |-> !fb_pulse); // R1
  AST_PULSE_SINGLE: assert property (@(posedge clk_in) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse); // R3
  AST_ACTIVE_AT_BOUNDARY: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run_q && !cycle_end) |=> $stable(act_r)); // R5
  AST_HALF_TOGGLE: assert property (@(posedge clk_in) disable iff (!rst_n)
    fb_pulse |=> (test_half != $past(test_half))); // R6
  AST_HALF_HOLD: assert property (@(posedge clk_in) disable iff (!rst_n)
    !fb_pulse |=> $stable(test_half)); // R6
  AST_ERR_HOLD: assert property (@(posedge clk_in) disable iff (!rst_n)
    !load_stb |=> $stable(ratio_err)); // R7
endmodule

// File: tb/pswd_divider_tb_top.sv
module pswd_divider_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_in = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] ratio_in = '0;
  logic        front_en = 1'b0;
  logic        load_stb = 1'b0;
  logic        fb_pulse, test_half, ratio_err;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string tag = "R1";

  int mrun = 0, mpv = 0, mpr = 0, mpfe = 0, mP = 0, mcnt = 0;
  int mpulse = 0, mhalf = 0, merr = 0, prev_pulse = 0;

  always #(CLK_PERIOD/2) clk_in = ~clk_in;

  pswd_divider dut_i (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .ratio_in (ratio_in),
    .front_en (front_en),
    .load_stb (load_stb),
    .fb_pulse (fb_pulse),
    .test_half(test_half),
    .ratio_err(ratio_err)
  );

  function automatic int split_period(input int r, input int fe);
    return (16 * (r >> 4) + (r & 15)) * (fe != 0 ? 2 : 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic model_step(input int ld, input int r, input int fe);
    int end_c, adopt;
    end_c  = (mrun != 0 && mcnt + 1 == mP) ? 1 : 0;
    adopt  = (mpv != 0 && (mrun == 0 || end_c != 0)) ? 1 : 0;
    mhalf  = mhalf ^ mpulse;
    mpulse = end_c;
    if (adopt != 0) begin
      mrun = 1; mP = split_period(mpr, mpfe); mcnt = 0;
    end else if (mrun != 0) begin
      mcnt = (end_c != 0) ? 0 : mcnt + 1;
    end
    if (ld != 0) begin
      mpr = r; mpfe = fe; mpv = 1;
      merr = ((r >> 4) == 0 || (r >> 4) < (r & 15)) ? 1 : 0;
    end else if (adopt != 0) begin
      mpv = 0;
    end
  endtask

  task automatic cyc(input int ld, input int r, input int fe);
    @(negedge clk_in);
    check({tag, " pulse"}, int'(fb_pulse), mpulse);
    check("R6 test_half", int'(test_half), mhalf);
    check("R7 ratio_err", int'(ratio_err), merr);
    if (prev_pulse != 0 && fb_pulse) check("R3 width", 1, 0);
    prev_pulse = int'(fb_pulse);
    load_stb = (ld != 0);
    if (ld != 0) begin
      ratio_in = 17'(r);
      front_en = (fe != 0);
    end
    model_step(ld, r, fe);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic load_run(input int m, input int a, input int fe, input int periods);
    int r;
    r = m * 16 + a;
    cyc(1, r, fe);
    idle(periods * split_period(r, fe) + 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk_in);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset values while held in reset, then idle without a load
    repeat (3) begin
      @(negedge clk_in);
      check("R1 reset pulse", int'(fb_pulse), 0);
      check("R1 reset half", int'(test_half), 0);
      check("R1 reset err", int'(ratio_err), 0);
    end
    rst_n = 1'b1;
    tag = "R1";
    idle(40);

    // R2 R8: bypassed front stage, fixed ratios including swallow extremes
    tag = "R2 R8";
    load_run(5, 3, 0, 3);
    load_run(1, 0, 0, 4);
    load_run(1, 1, 0, 4);
    load_run(15, 15, 0, 3);
    load_run(300, 15, 0, 2);

    // R4: front stage selected
    tag = "R4";
    load_run(7, 2, 1, 3);
    load_run(2, 2, 1, 3);

    // R5: reloads mid-cycle; the later strobe must win at the boundary
    tag = "R5";
    cyc(1, 20 * 16 + 4, 0);
    idle(50);
    cyc(1, 9 * 16 + 6, 1);
    idle(3);
    cyc(1, 12 * 16 + 9, 0);
    idle(3 * 324);

    // R7: error flag on bad splits, overwritten before any boundary
    tag = "R7";
    while (mcnt != 1) cyc(0, 0, 0);
    cyc(1, 2 * 16 + 9, 0);
    cyc(1, 0, 0);
    cyc(1, 12 * 16 + 9, 0);
    idle(3 * 201);

    // R2 R4 R8: randomized valid ratios with random front-stage choice
    tag = "R2 R4 R8";
    for (int k = 0; k < 14; k++) begin
      int m, a, fe;
      m  = int'($urandom_range(1, 40));
      a  = int'($urandom_range(0, (m < 15) ? m : 15));
      fe = int'($urandom_range(0, 1));
      load_run(m, a, fe, 3);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule